// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Loader

This block takes 18-bit configuration words from a slow three-wire serial port (shift clock, serial data, load strobe) and turns them into the control fields of a frequency synthesizer. The port lines are brought into the system clock domain by synchronisers, and edges are detected there. Each rising shift-clock edge moves one data bit into an 18-bit shift register, most significant bit first. A rising load strobe copies the word into one of two holding registers. The bit shifted in last selects which one: the reference register or the feedback register.

The reference register holds the reference divide ratio, the charge-pump high-impedance flag, the phase-detector polarity and a lock-detect routing code. The routing code is decoded to one-hot. The feedback register holds the swallow count, the main count and two power-control bits. These two bits, together with a chip-enable input, are decoded into one of four power modes. The block also produces a power-down flag. An asynchronous power-down raises this flag at once. A synchronous power-down raises it only once no charge-pump pulse is in progress. The serial port keeps accepting words in every power mode.

Top module: `cfg_loader`

## Requirements
- R1: Data is sampled at each synchronised rising edge of `sck`, MSB first. On a rising edge of `sle`, the last 18 bits shifted in are latched. Bit 0 (the last bit in) selects the target: 0 for the feedback register, 1 for the reference register. The register that is not selected keeps its value, and neither register changes without a load edge.
- R2: A reference word drives these outputs: bits 10:1 to `ref_div`, bit 11 to `pump_hiz` (1 = high impedance), bit 12 to `pd_positive` (1 = positive polarity) and bits 15:13 to `lock_code`. Bits 17:16 have no effect.
- R3: A reference word whose bits 10:1 are below 2 is rejected as a whole, and all reference outputs keep their previous values.
- R4: A feedback word drives these outputs: bit 1 is the power-down bit, bit 2 is the counter-reset bit, bits 7:3 go to `swallow_a` and bits 17:8 go to `main_b`.
- R5: `lock_route` is one-hot in `lock_code`: code 0 sets bit 0 (digital lock detect), 1 sets bit 1 (analog lock detect), 2 sets bit 2 (reference divider), 3 sets bit 3 (feedback divider) and 4 sets bit 4 (test). Codes 5 to 7 give all zeros.
- R6: With `chip_en` high, `pwr_mode` = {counter reset, power-down}: 0 normal, 1 synchronous power-down, 2 counter reset, 3 asynchronous power-down. `pwr_down` is 1 in mode 3.
- R7: With `chip_en` low, `pwr_mode` is 3 and `pwr_down` is 1 in the same cycle, whatever the register bits are.
- R8: In mode 1, `pwr_down` rises only on the clock edge after a cycle in which `pump_busy` was low. While `pump_busy` stays high, `pwr_down` stays 0. In modes 0 and 2, `pwr_down` is 0.
- R9: Words are shifted and latched normally in every power mode, including while `chip_en` is low.
- R10: After reset, every register field is zero, so `pwr_mode` is 0 and `lock_route` is 00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial shift clock (asynchronous) |
| sdi | input | 1 | Serial data (asynchronous) |
| sle | input | 1 | Load strobe (asynchronous) |
| chip_en | input | 1 | Chip enable; low forces asynchronous power-down |
| pump_busy | input | 1 | Charge-pump pulse in progress |
| ref_div | output | 10 | Reference divide ratio |
| pump_hiz | output | 1 | Charge pump high impedance |
| pd_positive | output | 1 | Phase detector polarity |
| lock_code | output | 3 | Raw lock-detect routing code |
| lock_route | output | 5 | One-hot lock-detect routing |
| swallow_a | output | 5 | Swallow count |
| main_b | output | 10 | Main count |
| pwr_mode | output | 2 | Decoded power mode |
| pwr_down | output | 1 | Power-down in effect |

## Verification
The bench sends random words to both registers and checks every field against a model. A wrong bit position or a wrong order would show up as scrambled fields. A swapped address bit would write the wrong register. It sends reference ratios of 0 and 1, which a loader without the range check would accept, and a ratio of exactly 2, which must be accepted. It holds `pump_busy` high in synchronous power-down to catch a design that powers down without waiting. It drops `chip_en` while loading words to catch a design that stalls the port or fails to override the mode bits.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   localparam int WORD_W  = 18;
   localparam int RDIV_W  = 10;
   localparam int SWAL_W  = 5;
   localparam int MAIN_W  = 10;
   localparam int LCODE_W = 3;
   localparam int LROUTES = 5;
   localparam int RDIV_MIN = 2;

   typedef enum logic [1:0] {
      PWR_NORMAL   = 2'd0,
      PWR_SYNC_PD  = 2'd1,
      PWR_CNT_RST  = 2'd2,
      PWR_ASYNC_PD = 2'd3
   } pwr_mode_e;

   typedef struct packed {
      logic [LCODE_W-1:0] lock_code;
      logic               pd_positive;
      logic               pump_hiz;
      logic [RDIV_W-1:0]  ratio;
   } ref_reg_t;

   typedef struct packed {
      logic [MAIN_W-1:0] main_b;
      logic [SWAL_W-1:0] swallow_a;
      logic              cnt_rst;
      logic              pd_bit;
   } fb_reg_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("bit_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/cfg_capture.sv
module cfg_capture
   import cfg_loader_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sck_lvl,
   input  logic     sdi_lvl,
   input  logic     sle_lvl,
   output ref_reg_t ref_q,
   output fb_reg_t  fb_q
);
   localparam int REF_W = $bits(ref_reg_t);
   localparam int FB_W  = $bits(fb_reg_t);

   generate
      if (FB_W != WORD_W - 1) begin : g_fb_bad
         $error("feedback layout must fill the word above the address bit");
      end
      if (REF_W > WORD_W - 1) begin : g_ref_bad
         $error("reference layout wider than the word");
      end
   endgenerate

   logic              sck_d, sle_d;
   logic [WORD_W-1:0] shreg;
   logic              sck_rise, sle_rise;
   ref_reg_t          ref_new;

   assign sck_rise = sck_lvl & ~sck_d;
   assign sle_rise = sle_lvl & ~sle_d;
   assign ref_new  = ref_reg_t'(shreg[REF_W:1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         sle_d <= 1'b0;
         shreg <= '0;
         ref_q <= '0;
         fb_q  <= '0;
      end else begin
         sck_d <= sck_lvl;
         sle_d <= sle_lvl;
         if (sck_rise) shreg <= {shreg[WORD_W-2:0], sdi_lvl};
         if (sle_rise) begin
            if (shreg[0]) begin
               if (ref_new.ratio >= RDIV_W'(RDIV_MIN)) ref_q <= ref_new;
            end else begin
               fb_q <= fb_reg_t'(shreg[WORD_W-1:1]);
            end
         end
      end
   end

   AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !sle_rise |=> ($stable(ref_q) && $stable(fb_q))) else $error("registers changed without load"); // R1
   AST_REF_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_q.ratio == '0) || (ref_q.ratio >= RDIV_W'(RDIV_MIN))) else $error("illegal ratio held"); // R3
endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
   import cfg_loader_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      chip_en,
   input  logic      cnt_rst,
   input  logic      pd_bit,
   input  logic      pump_busy,
   output pwr_mode_e mode,
   output logic      pwr_down
);
   logic sync_pd_q;

   always_comb begin
      if (!chip_en) mode = PWR_ASYNC_PD;
      else          mode = pwr_mode_e'({cnt_rst, pd_bit});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    sync_pd_q <= 1'b0;
      else if (mode != PWR_SYNC_PD)  sync_pd_q <= 1'b0;
      else if (!pump_busy)           sync_pd_q <= 1'b1;
   end

   assign pwr_down = (mode == PWR_ASYNC_PD) | ((mode == PWR_SYNC_PD) & sync_pd_q);

   AST_CE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |-> (pwr_down && mode == PWR_ASYNC_PD)) else $error("chip enable override lost"); // R7
   AST_SYNC_PD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PWR_SYNC_PD && $rose(pwr_down)) |-> !$past(pump_busy)) else $error("sync power-down ignored pump"); // R8
   AST_RUN_MODES_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PWR_NORMAL || mode == PWR_CNT_RST) |-> !pwr_down) else $error("power-down in run mode"); // R6
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
   import cfg_loader_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck,
   input  logic               sdi,
   input  logic               sle,
   input  logic               chip_en,
   input  logic               pump_busy,
   output logic [RDIV_W-1:0]  ref_div,
   output logic               pump_hiz,
   output logic               pd_positive,
   output logic [LCODE_W-1:0] lock_code,
   output logic [LROUTES-1:0] lock_route,
   output logic [SWAL_W-1:0]  swallow_a,
   output logic [MAIN_W-1:0]  main_b,
   output logic [1:0]         pwr_mode,
   output logic               pwr_down
);
   logic      sck_lvl, sdi_lvl, sle_lvl;
   ref_reg_t  ref_q;
   fb_reg_t   fb_q;
   pwr_mode_e mode;

   bit_sync #(.STAGES(SYNC_STAGES)) u_sync_sck (.clk(clk), .rst_n(rst_n), .din(sck), .dout(sck_lvl));
   bit_sync #(.STAGES(SYNC_STAGES)) u_sync_sdi (.clk(clk), .rst_n(rst_n), .din(sdi), .dout(sdi_lvl));
   bit_sync #(.STAGES(SYNC_STAGES)) u_sync_sle (.clk(clk), .rst_n(rst_n), .din(sle), .dout(sle_lvl));

   cfg_capture u_capture (
      .clk(clk), .rst_n(rst_n),
      .sck_lvl(sck_lvl), .sdi_lvl(sdi_lvl), .sle_lvl(sle_lvl),
      .ref_q(ref_q), .fb_q(fb_q)
   );

   pwr_ctrl u_pwr (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
      .cnt_rst(fb_q.cnt_rst), .pd_bit(fb_q.pd_bit), .pump_busy(pump_busy),
      .mode(mode), .pwr_down(pwr_down)
   );

   assign ref_div     = ref_q.ratio;
   assign pump_hiz    = ref_q.pump_hiz;
   assign pd_positive = ref_q.pd_positive;
   assign lock_code   = ref_q.lock_code;
   assign swallow_a   = fb_q.swallow_a;
   assign main_b      = fb_q.main_b;
   assign pwr_mode    = mode;

   generate
      for (genvar i = 0; i < LROUTES; i++) begin : g_route
         assign lock_route[i] = (ref_q.lock_code == LCODE_W'(i));
      end
   endgenerate

   AST_ROUTE_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lock_route)) else $error("lock route not one-hot"); // R5
endmodule

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;
   logic clk = 0, rst_n = 0;
   logic sck = 0, sdi = 0, sle = 0, chip_en = 1, pump_busy = 0;
   logic [9:0] ref_div, main_b;
   logic pump_hiz, pd_positive, pwr_down;
   logic [2:0] lock_code;
   logic [4:0] lock_route, swallow_a;
   logic [1:0] pwr_mode;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model
   logic [9:0] m_rdiv, m_b; logic m_hiz, m_pol, m_cr, m_pd;
   logic [2:0] m_code; logic [4:0] m_a;

   cfg_loader u_dut (.*);

   always #10 clk = ~clk;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wclk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(logic [17:0] w);
      for (int i = 17; i >= 0; i--) begin
         sdi = w[i]; wclk(3); sck = 1; wclk(3); sck = 0;
      end
      wclk(2); sle = 1; wclk(3); sle = 0; wclk(6);
      if (w[0]) begin
         if (w[10:1] >= 2) begin
            m_rdiv = w[10:1]; m_hiz = w[11]; m_pol = w[12]; m_code = w[15:13];
         end
      end else begin
         m_pd = w[1]; m_cr = w[2]; m_a = w[7:3]; m_b = w[17:8];
      end
   endtask

   function automatic logic [4:0] exp_route(logic [2:0] c);
      return (c <= 3'd4) ? 5'(1 << c) : 5'd0;
   endfunction

   function automatic logic [1:0] exp_mode();
      return chip_en ? {m_cr, m_pd} : 2'd3;
   endfunction

   function automatic logic exp_down();
      logic [1:0] md = exp_mode();
      return (md == 2'd3) || (md == 2'd1 && !pump_busy);
   endfunction

   task automatic check_all(string tag);
      chk({tag, " R1 R2 ref_div"}, ref_div, m_rdiv);
      chk({tag, " R2 pump_hiz"}, pump_hiz, m_hiz);
      chk({tag, " R2 pd_positive"}, pd_positive, m_pol);
      chk({tag, " R2 lock_code"}, lock_code, m_code);
      chk({tag, " R5 lock_route"}, lock_route, exp_route(m_code));
      chk({tag, " R4 swallow_a"}, swallow_a, m_a);
      chk({tag, " R4 main_b"}, main_b, m_b);
      chk({tag, " R6 pwr_mode"}, pwr_mode, exp_mode());
      chk({tag, " R6 pwr_down"}, pwr_down, exp_down());
   endtask

   initial begin
      void'($urandom(32'h5eed_c0de));
      {m_rdiv, m_b, m_hiz, m_pol, m_cr, m_pd, m_code, m_a} = '0;
      wclk(4); rst_n = 1; wclk(2);
      check_all("reset R10");
      chk("R10 lock_route reset", lock_route, 5'b00001);

      // directed: ref word with ignored top bits set
      send({2'b11, 3'd2, 1'b1, 1'b0, 10'd2, 1'b1});
      check_all("R2 ratio=2 top bits ignored");
      send({2'b00, 3'd2, 1'b1, 1'b0, 10'd2, 1'b1});
      check_all("R2 top bits no effect");
      // R3: ratios 0 and 1 rejected
      send({2'b00, 3'd4, 1'b0, 1'b1, 10'd1, 1'b1});
      chk("R3 ratio 1 rejected", ref_div, 10'd2);
      check_all("R3 reject1");
      send({2'b00, 3'd7, 1'b0, 1'b1, 10'd0, 1'b1});
      chk("R3 ratio 0 rejected lock_code", lock_code, 3'd2);
      // R5: every code
      for (int c = 0; c < 8; c++) begin
         send({2'b00, 3'(c), 1'b0, 1'b0, 10'd100, 1'b1});
         chk("R5 route", lock_route, exp_route(3'(c)));
      end
      // R1: feedback word leaves reference untouched
      send({10'd1023, 5'd31, 1'b0, 1'b0, 1'b0});
      chk("R1 ref kept after fb load", ref_div, 10'd100);
      check_all("R4 fb max");

      // R8: synchronous power-down waits for pump
      pump_busy = 1;
      send({10'd40, 5'd3, 1'b0, 1'b1, 1'b0});
      chk("R8 held off while pump busy", pwr_down, 1'b0);
      chk("R6 mode sync", pwr_mode, 2'd1);
      pump_busy = 0;
      @(posedge clk); #1;
      chk("R8 down after pump idle", pwr_down, 1'b1);
      pump_busy = 1; wclk(3);
      chk("R8 stays down", pwr_down, 1'b1);
      pump_busy = 0;
      // counter reset then async
      send({10'd40, 5'd3, 1'b1, 1'b0, 1'b0});
      check_all("R6 counter reset");
      send({10'd40, 5'd3, 1'b1, 1'b1, 1'b0});
      check_all("R6 async pd");
      send({10'd40, 5'd3, 1'b0, 1'b0, 1'b0});
      check_all("R6 normal");

      // R7 and R9: chip enable low
      @(posedge clk); #1; chip_en = 0; #1;
      chk("R7 mode immediate", pwr_mode, 2'd3);
      chk("R7 down immediate", pwr_down, 1'b1);
      send({10'd555, 5'd9, 1'b0, 1'b0, 1'b0});
      check_all("R9 load with chip_en low fb");
      send({2'b01, 3'd3, 1'b1, 1'b1, 10'd777, 1'b1});
      check_all("R9 load with chip_en low ref");
      chip_en = 1; wclk(1);
      check_all("R7 release");

      // random words
      for (int k = 0; k < 60; k++) begin
         logic [17:0] w = 18'($urandom);
         if (k % 7 == 0) w[10:1] = 10'($urandom_range(0, 1));
         send(w);
         check_all("R1 random");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule